// File: doc/BRIEF.md
# Periodic Call Injector

This block runs beside a simple in-order instruction pipeline and makes it call a service routine at a regular interval. Software programs a period. A countdown then runs continuously and, each time it wraps, marks a call request as pending. At each fetch slot the block decides whether it may take that slot. When it may, it replaces the fetched instruction with a link instruction. The link saves the return address and the carry and zero flags into one fixed register and jumps through a second fixed register. The replaced instruction is fetched again after the routine returns.

A pending request waits while the pipeline is in the middle of something that must not be split. That covers a prefix word whose operand is still waiting for its consumer, the instruction that follows an operand-alter prefix, and a hardware repeat loop that has not finished. It also waits inside a software-locked region and for as long as the service routine is running. Requests never nest. Any number of wraps that occur while a request is already pending count as one request.

A three-state gate machine controls the decision:
- `GATE_OPEN`: injection is allowed.
- `GATE_SHADOW`: an alter prefix has issued, and the next real instruction must go through untouched.
- `GATE_SERVICE`: the service routine is running.

The machine has five transitions:
- OPEN→SERVICE on an injection.
- OPEN→SHADOW when an alter prefix issues.
- SHADOW→OPEN when a non-alter instruction issues.
- SHADOW→SHADOW when another alter prefix issues.
- SERVICE→OPEN on the return strobe.

Top module: `tick_call_injector`

## Requirements
- R1: A period value of zero stops all requests. With period zero, `call_inject` never rises, whatever the other inputs do.
- R2: Writing a nonzero period N in cycle w makes the first request visible in cycle w+N+1. Later wraps follow every N cycles. With free slots and a prompt return, consecutive injections for N ≥ 2 are N cycles apart.
- R3: A pending request is kept until an injection takes it. Several wraps while it is pending merge into one request, so only one injection follows them.
- R4: A period write reloads the countdown and drops any pending request in the same edge. The next injection is then timed from the write alone.
- R5: No injection occurs while `prefix_wait` is high. A request blocked this way is injected in the first slot after it falls.
- R6: When a slot issues an alter prefix (`slot_is_alter` high, no injection), the next slot that holds a non-alter instruction issues normally. Injection becomes possible only in the slot after that one.
- R7: No injection occurs while `repeat_busy` is high. A request blocked this way is injected in the first slot after it falls.
- R8: A `lock_req` pulse inhibits injection from the following cycle. A `free_req` pulse lifts the inhibit from the following cycle. If both arrive in the same cycle, the lock wins.
- R9: `in_service` rises in the same cycle as `call_inject` and holds until the cycle after a `service_ret` pulse. No injection occurs while it is set.
- R10: The injected word places the fields as follows:
  - bits [8:0]: target register 0x1F5
  - bits [17:9]: save register 0x1F4
  - bit 18: save the zero flag, set to 1
  - bit 19: save the carry flag, set to 1
  - bits [31:20]: opcode 0xD5C
- R11: Injection happens only in a cycle with `fetch_slot` high. A pending request waits through slot-free cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_wr | input | 1 | Load a new period |
| period_val | input | PERIOD_W | Period in clocks; 0 disables |
| lock_req | input | 1 | Enter a region that must not be interrupted |
| free_req | input | 1 | Leave that region |
| fetch_slot | input | 1 | Decode takes a fetched instruction this cycle |
| slot_is_alter | input | 1 | The instruction in this slot is an operand-alter prefix |
| prefix_wait | input | 1 | An operand-extension value is waiting for its consumer |
| repeat_busy | input | 1 | A hardware repeat loop is still iterating |
| service_ret | input | 1 | The service routine returns |
| call_inject | output | 1 | This slot is replaced by the link word |
| call_word | output | WORD_W | The link instruction word |
| in_service | output | 1 | The service routine is in progress |

## Verification
The bench builds the block with a 5-bit period. That small width lets it sweep every nonzero period from 1 to 31 for first-request timing, and every period from 2 to 9 for the spacing between injections. With the period fixed small, the bench also sweeps:
- the length of prefix, repeat and lock windows;
- the position of an alter prefix relative to the wrap;
- the gaps between fetch slots.

For each case the expected injection cycle is computed arithmetically. That makes every one-cycle slip, lost request and duplicate injection show up as a wrong cycle number.

// File: rtl/tci_pkg.sv
package tci_pkg;

    typedef enum logic [1:0] {
        GATE_OPEN    = 2'd0,
        GATE_SHADOW  = 2'd1,
        GATE_SERVICE = 2'd2
    } gate_state_e;

endpackage

// File: rtl/tci_countdown.sv
// Period register, free-running countdown and the pending-request bit.
module tci_countdown #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                period_wr,
    input  logic [PERIOD_W-1:0] period_val,
    input  logic                take,
    output logic                pend
);
    localparam logic [PERIOD_W-1:0] ONE  = PERIOD_W'(1);
    localparam logic [PERIOD_W-1:0] ZERO = '0;

    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W-1:0] count_q;
    logic                pend_q;
    logic                enabled;
    logic                wrap;

    assign enabled = (period_q != ZERO);
    assign wrap    = enabled && (count_q == ZERO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= ZERO;
            count_q  <= ZERO;
            pend_q   <= 1'b0;
        end else if (period_wr) begin
            // new period: restart the count and forget any old request
            period_q <= period_val;
            count_q  <= (period_val == ZERO) ? ZERO : period_val - ONE;
            pend_q   <= 1'b0;
        end else if (enabled) begin
            count_q  <= wrap ? period_q - ONE : count_q - ONE;
            // a wrap in the taking cycle starts a fresh request
            pend_q   <= wrap | (pend_q & ~take);
        end else begin
            pend_q   <= pend_q & ~take;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/tci_lock.sv
// Software lock region flag; lock wins when both strobes coincide.
module tci_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_req,
    input  logic free_req,
    output logic locked
);
    logic lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (lock_req) begin
            lock_q <= 1'b1;
        end else if (free_req) begin
            lock_q <= 1'b0;
        end
    end

    assign locked = lock_q;

endmodule

// File: rtl/tci_gate.sv
// Decides whether the current fetch slot may be replaced by the call.
module tci_gate
    import tci_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic fetch_slot,
    input  logic slot_is_alter,
    input  logic prefix_wait,
    input  logic repeat_busy,
    input  logic locked,
    input  logic service_ret,
    output logic fire,
    output logic in_service
);
    gate_state_e state_q;
    gate_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        fire = (state_q == GATE_OPEN) && pend && fetch_slot &&
               !prefix_wait && !repeat_busy && !locked;
        in_service = (state_q == GATE_SERVICE) || fire;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OPEN: begin
                if (fire) begin
                    state_d = GATE_SERVICE;
                end else if (fetch_slot && slot_is_alter) begin
                    state_d = GATE_SHADOW;
                end
            end
            GATE_SHADOW: begin
                if (fetch_slot && !slot_is_alter) begin
                    state_d = GATE_OPEN;
                end
            end
            GATE_SERVICE: begin
                if (service_ret) begin
                    state_d = GATE_OPEN;
                end
            end
            default: state_d = GATE_OPEN;
        endcase
    end

endmodule

// File: rtl/tci_word.sv
// Builds the link instruction word from the field parameters.
module tci_word #(
    parameter int WORD_W     = 32,
    parameter int REG_AW     = 9,
    parameter int LINK_OPC   = 'hD5C,
    parameter int SAVE_REG   = 'h1F4,
    parameter int TARGET_REG = 'h1F5,
    parameter bit SAVE_FLAGS = 1'b1
) (
    output logic [WORD_W-1:0] word
);
    localparam int OPC_W = WORD_W - 2 - 2 * REG_AW;

    logic [1:0] flag_bits;

    generate
        if (SAVE_FLAGS) begin : g_flags
            assign flag_bits = 2'b11;
        end else begin : g_noflags
            assign flag_bits = 2'b00;
        end
    endgenerate

    assign word = {OPC_W'(LINK_OPC), flag_bits,
                   REG_AW'(SAVE_REG), REG_AW'(TARGET_REG)};

endmodule

// File: rtl/tick_call_injector.sv
module tick_call_injector #(
    parameter int PERIOD_W   = 16,
    parameter int WORD_W     = 32,
    parameter int REG_AW     = 9,
    parameter int LINK_OPC   = 'hD5C,
    parameter int SAVE_REG   = 'h1F4,
    parameter int TARGET_REG = 'h1F5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                period_wr,
    input  logic [PERIOD_W-1:0] period_val,
    input  logic                lock_req,
    input  logic                free_req,
    input  logic                fetch_slot,
    input  logic                slot_is_alter,
    input  logic                prefix_wait,
    input  logic                repeat_busy,
    input  logic                service_ret,
    output logic                call_inject,
    output logic [WORD_W-1:0]   call_word,
    output logic                in_service
);
    logic pend_w;
    logic locked_w;
    logic fire_w;

    tci_countdown #(.PERIOD_W(PERIOD_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_wr  (period_wr),
        .period_val (period_val),
        .take       (fire_w),
        .pend       (pend_w)
    );

    tci_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_req (lock_req),
        .free_req (free_req),
        .locked   (locked_w)
    );

    tci_gate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .pend          (pend_w),
        .fetch_slot    (fetch_slot),
        .slot_is_alter (slot_is_alter),
        .prefix_wait   (prefix_wait),
        .repeat_busy   (repeat_busy),
        .locked        (locked_w),
        .service_ret   (service_ret),
        .fire          (fire_w),
        .in_service    (in_service)
    );

    tci_word #(
        .WORD_W     (WORD_W),
        .REG_AW     (REG_AW),
        .LINK_OPC   (LINK_OPC),
        .SAVE_REG   (SAVE_REG),
        .TARGET_REG (TARGET_REG),
        .SAVE_FLAGS (1'b1)
    ) u_word (
        .word (call_word)
    );

    assign call_inject = fire_w;

endmodule

// File: rtl/tci_injector_chk.sv
module tci_injector_chk (
    input logic clk,
    input logic rst_n,
    input logic period_wr,
    input logic lock_req,
    input logic free_req,
    input logic fetch_slot,
    input logic slot_is_alter,
    input logic prefix_wait,
    input logic repeat_busy,
    input logic service_ret,
    input logic call_inject,
    input logic in_service,
    input logic pend
);
    a_r11_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
        call_inject |-> fetch_slot);

    a_r3_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        call_inject |-> pend);

    a_r4_write_drops: assert property (@(posedge clk) disable iff (!rst_n)
        period_wr |=> !pend);

    a_r5_prefix_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        call_inject |-> !prefix_wait);

    a_r7_repeat_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        call_inject |-> !repeat_busy);

    a_r6_alter_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_slot && slot_is_alter && !in_service) |=> !call_inject);

    a_r8_lock_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_req && !free_req) |=> !call_inject);

    a_r9_no_nest: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && !service_ret) |=> !call_inject);

    a_r9_service_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && !service_ret) |=> in_service);

    a_r9_flag_with_call: assert property (@(posedge clk) disable iff (!rst_n)
        call_inject |-> in_service);

endmodule

bind tick_call_injector tci_injector_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .period_wr     (period_wr),
    .lock_req      (lock_req),
    .free_req      (free_req),
    .fetch_slot    (fetch_slot),
    .slot_is_alter (slot_is_alter),
    .prefix_wait   (prefix_wait),
    .repeat_busy   (repeat_busy),
    .service_ret   (service_ret),
    .call_inject   (call_inject),
    .in_service    (in_service),
    .pend          (pend_w)
);

// File: tb/tick_call_injector_bench.sv
module tick_call_injector_bench;
    localparam int CLK_NS = 10;
    localparam int PW     = 5;
    localparam int NONE   = -9;
    localparam logic [31:0] EXP_WORD = {12'hD5C, 1'b1, 1'b1, 9'h1F4, 9'h1F5};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          period_wr = 1'b0;
    logic [PW-1:0] period_val = '0;
    logic          lock_req = 1'b0;
    logic          free_req = 1'b0;
    logic          fetch_slot = 1'b0;
    logic          slot_is_alter = 1'b0;
    logic          prefix_wait = 1'b0;
    logic          repeat_busy = 1'b0;
    logic          service_ret = 1'b0;
    logic          call_inject;
    logic [31:0]   call_word;
    logic          in_service;

    int tests = 0;
    int fails = 0;

    tick_call_injector #(.PERIOD_W(PW)) u_tick_call_injector (
        .clk(clk), .rst_n(rst_n), .period_wr(period_wr), .period_val(period_val),
        .lock_req(lock_req), .free_req(free_req), .fetch_slot(fetch_slot),
        .slot_is_alter(slot_is_alter), .prefix_wait(prefix_wait),
        .repeat_busy(repeat_busy), .service_ret(service_ret),
        .call_inject(call_inject), .call_word(call_word), .in_service(in_service)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        period_wr = 0; lock_req = 0; free_req = 0; fetch_slot = 0;
        slot_is_alter = 0; prefix_wait = 0; repeat_busy = 0; service_ret = 0;
    endtask

    // Every task starts just after a falling edge and ends just after one.
    task automatic write_p(input int n);
        idle();
        period_wr = 1; period_val = PW'(n);
        #1; @(negedge clk);
        period_wr = 0;
    endtask

    task automatic find_inj(input int lim, output int t);
        t = -1;
        for (int rel = 1; rel <= lim; rel++) begin
            #1;
            if (call_inject) begin
                t = rel;
                chk(call_word == EXP_WORD, "R10 word", call_word, EXP_WORD);
                chk(in_service == 1'b1, "R9 flag with call", in_service, 1);
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic end_svc();
        idle();
        service_ret = 1; free_req = 1;
        #1; @(negedge clk);
        idle();
    endtask

    // write period n at rel 0, then drive inhibit windows per relative cycle
    task automatic scen(input int n, input int a0, input int a1, input int r0, input int r1,
                        input int alt_at, input int lk, input int fr,
                        input int g0, input int g1, input int lim, output int t);
        write_p(n);
        t = -1;
        for (int rel = 1; rel <= lim; rel++) begin
            fetch_slot    = !(rel >= g0 && rel <= g1);
            prefix_wait   = (rel >= a0 && rel <= a1);
            repeat_busy   = (rel >= r0 && rel <= r1);
            slot_is_alter = (rel == alt_at);
            lock_req      = (rel == lk);
            free_req      = (rel == fr);
            #1;
            if (call_inject) begin
                t = rel;
                chk(call_word == EXP_WORD, "R10 word", call_word, EXP_WORD);
                chk(in_service == 1'b1, "R9 flag with call", in_service, 1);
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        end_svc();
    endtask

    initial begin
        #(CLK_NS * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int t;
        int t2;
        idle();
        repeat (3) @(negedge clk);
        #1;
        chk(call_inject == 0, "R11 reset inject", call_inject, 0);
        chk(in_service == 0, "R9 reset flag", in_service, 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: nonzero period then zero period -> nothing
        scen(4, NONE, NONE, NONE, NONE, NONE, NONE, NONE, NONE, NONE, 40, t);
        chk(t == 5, "R2 first call n=4", t, 5);
        scen(0, NONE, NONE, NONE, NONE, NONE, NONE, NONE, NONE, NONE, 80, t);
        chk(t == -1, "R1 zero period", t, -1);

        // R2: first request timing for every period
        for (int n = 1; n < 32; n++) begin
            scen(n, NONE, NONE, NONE, NONE, NONE, NONE, NONE, NONE, NONE, 60, t);
            chk(t == n + 1, "R2 first call sweep", t, n + 1);
        end

        // R2/R3: spacing between calls with a prompt return
        for (int n = 2; n < 10; n++) begin
            write_p(n);
            fetch_slot = 1;
            find_inj(60, t);
            chk(t == n + 1, "R2 periodic first", t, n + 1);
            service_ret = 1; #1; @(negedge clk); service_ret = 0;
            find_inj(60, t2);
            chk(t2 == n - 1, "R2 periodic spacing", t2 + 2, n + 1);
            end_svc();
        end

        // R9 no nesting, R3 request kept through service
        write_p(3);
        fetch_slot = 1;
        find_inj(20, t);
        chk(t == 4, "R9 call before service", t, 4);
        for (int k = 0; k < 12; k++) begin
            #1;
            chk(call_inject == 0, "R9 no nested call", call_inject, 0);
            chk(in_service == 1, "R9 flag held", in_service, 1);
            @(negedge clk);
        end
        service_ret = 1; #1;
        chk(in_service == 1, "R9 flag in return cycle", in_service, 1);
        @(negedge clk);
        service_ret = 0; #1;
        chk(call_inject == 1, "R3 pending kept through service", call_inject, 1);
        @(negedge clk);
        fetch_slot = 0; service_ret = 1; #1; @(negedge clk);
        service_ret = 0; #1;
        chk(in_service == 0, "R9 flag cleared", in_service, 0);
        @(negedge clk);
        end_svc();

        // R3 merge and R11 slot-free waiting
        write_p(8);
        for (int rel = 1; rel <= 25; rel++) begin
            #1;
            chk(call_inject == 0, "R11 no slot no call", call_inject, 0);
            @(negedge clk);
        end
        fetch_slot = 1;
        find_inj(5, t);
        chk(t == 1, "R3 merged call at first slot", t, 1);
        fetch_slot = 0; service_ret = 1; #1; @(negedge clk);
        service_ret = 0; fetch_slot = 1;
        find_inj(30, t);
        chk(t == 6, "R3 single call for merged wraps", t + 27, 33);
        end_svc();

        // R4: rewrite drops pending request
        write_p(6);
        repeat (9) begin #1; @(negedge clk); end
        write_p(5);
        fetch_slot = 1;
        find_inj(30, t);
        chk(t == 6, "R4 rewrite restarts", t, 6);
        end_svc();

        // R5: prefix wait windows
        for (int e = 4; e <= 12; e++) begin
            scen(3, 2, e, NONE, NONE, NONE, NONE, NONE, NONE, NONE, 60, t);
            chk(t == e + 1, "R5 prefix wait", t, e + 1);
        end

        // R7: repeat windows
        for (int e = 4; e <= 12; e++) begin
            scen(3, NONE, NONE, 1, e, NONE, NONE, NONE, NONE, NONE, 60, t);
            chk(t == e + 1, "R7 repeat loop", t, e + 1);
        end

        // R6: alter prefix positions
        for (int a = 1; a <= 6; a++) begin
            scen(6, NONE, NONE, NONE, NONE, a, NONE, NONE, NONE, NONE, 60, t);
            chk(t == ((a == 6) ? 8 : 7), "R6 alter shadow", t, (a == 6) ? 8 : 7);
        end
        for (int g = 1; g <= 4; g++) begin
            scen(6, NONE, NONE, NONE, NONE, 6, NONE, NONE, 7, 6 + g, 60, t);
            chk(t == 8 + g, "R6 alter shadow with gap", t, 8 + g);
        end

        // R11: slot gaps
        for (int g = 1; g <= 6; g++) begin
            scen(5, NONE, NONE, NONE, NONE, NONE, NONE, NONE, 6, 5 + g, 60, t);
            chk(t == 6 + g, "R11 slot gap", t, 6 + g);
        end

        // R8: lock regions
        for (int f = 6; f <= 12; f++) begin
            scen(5, NONE, NONE, NONE, NONE, NONE, 3, f, NONE, NONE, 60, t);
            chk(t == f + 1, "R8 lock region", t, f + 1);
        end
        scen(5, NONE, NONE, NONE, NONE, NONE, 6, 9, NONE, NONE, 60, t);
        chk(t == 6, "R8 lock effective next cycle", t, 6);

        // combined inhibits: latest release wins
        scen(4, 2, 7, 3, 9, NONE, 2, 11, NONE, NONE, 60, t);
        chk(t == 12, "R5 R7 R8 combined", t, 12);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule